// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and drives two active-high processor requests: a normal interrupt and a fast interrupt. Each source can be raised by its hardware line or by a software-set bit. It can be enabled or masked, and it can be steered to either request. A small register bus with a one-cycle registered read path gives software access to all of the configuration and status.

Sixteen vector slots each bind one source to a handler address. Slot 0 has the highest priority. Enabled sources that no slot claims fall to a shared default address, which sits below every slot. The controller keeps a current priority level in hardware, with one saved level per priority.

A handler starts by reading the vector register. That read returns the handler address and raises the current level to that of the pending interrupt. The handler ends by writing the vector register, which restores the saved level. While a handler runs, only a source of strictly higher priority can raise the normal request again, so nesting is handled in hardware.

Top module: `nest_vic`

## Requirements
- R1: The raw status of a source is its hardware line OR its software bit. The normal status is raw AND enable AND NOT fast-select. `fiq_o` is high whenever raw AND fast-select is non-zero. The read-only views are: normal status at 0x00, fast status at 0x04 and raw status at 0x08. Fast-select is read/write at 0x0C.
- R2: A write to 0x10 sets the enable bits that are 1 in the data. A write to 0x14 clears them. Zero data bits leave enables unchanged. Enables read back at 0x10.
- R3: A write to 0x18 sets software bits and a write to 0x1C clears them, with 1s active. The software bits read back at 0x18.
- R4: A write to 0x00 changes no state and no output. The protection bit at 0x20 stores data bit 0.
- R5: Vector addresses are at 0x100 + 4·n and control bytes at 0x200 + 4·n, for slot n = 0..15. In a control byte, bit 5 enables the slot and bits 4:0 name the source; only bits 5:0 are stored. The pending slot is the lowest-numbered enabled slot whose source is set in the normal status. Any other normal-status source is pending at the default level.
- R6: A read of 0x30 when the pending level is above the current level saves the current level, raises the current level to the pending one, and returns that slot's address. For the default level it returns the default address, read/write at 0x34. Otherwise the level is unchanged and the read returns the current slot's address, or the default address when the current level is the default or idle.
- R7: While a level is active, a source of equal or lower priority cannot raise `irq_o`, and a higher-priority slot source can.
- R8: A write of any data to 0x30 restores the level saved when the current level was entered. At idle the write has no effect.
- R9: `irq_o` is high exactly when some normal-status source belongs to a slot numbered below the current level. At idle, any normal-status source qualifies.
- R10: After reset, the enables, fast-select, software bits, vector addresses, control bytes and default address are zero, the level is idle, and both outputs are low.
- R11: The words at 0xFE0..0xFFC read as 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Hardware interrupt lines, level sensitive |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The current level and the saved levels are not visible as registers, so a fault in them shows up in only two places. The next vector read returns the wrong handler address. `irq_o` fails to follow the priority rule, and it does so on the first cycle after the faulty acknowledge or restore. The bench therefore checks `irq_o` and `fiq_o` after every operation, so a wrong mask or level is caught within one access. Nested sequences with pre-emption, restore and idle restores expose a corrupted saved level when it is popped.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [11:0] OFS_NSTAT   = 12'h000;
  localparam logic [11:0] OFS_FSTAT   = 12'h004;
  localparam logic [11:0] OFS_RAW     = 12'h008;
  localparam logic [11:0] OFS_FSEL    = 12'h00C;
  localparam logic [11:0] OFS_EN_SET  = 12'h010;
  localparam logic [11:0] OFS_EN_CLR  = 12'h014;
  localparam logic [11:0] OFS_SW_SET  = 12'h018;
  localparam logic [11:0] OFS_SW_CLR  = 12'h01C;
  localparam logic [11:0] OFS_PROT    = 12'h020;
  localparam logic [11:0] OFS_VEC     = 12'h030;
  localparam logic [11:0] OFS_DEF     = 12'h034;
  localparam logic [11:0] OFS_VADDR   = 12'h100;
  localparam logic [11:0] OFS_VCTL    = 12'h200;
  localparam logic [11:0] OFS_ID      = 12'hFE0;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_lines,
  input  logic [NSRC-1:0] wdata,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            sw_set_we,
  input  logic            sw_clr_we,
  input  logic            fsel_we,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] fsel_q,
  output logic [NSRC-1:0] soft_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  logic [NSRC-1:0] en_d, fsel_d, soft_d;
  logic            en_upd, soft_upd;

  assign en_upd   = en_set_we | en_clr_we;
  assign soft_upd = sw_set_we | sw_clr_we;

  always_comb begin
    en_d   = enable_q;
    soft_d = soft_q;
    fsel_d = wdata;
    if (en_set_we) en_d = enable_q | wdata;
    if (en_clr_we) en_d = enable_q & ~wdata;
    if (sw_set_we) soft_d = soft_q | wdata;
    if (sw_clr_we) soft_d = soft_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      fsel_q   <= '0;
      soft_q   <= '0;
    end else begin
      if (en_upd)   enable_q <= en_d;
      if (soft_upd) soft_q   <= soft_d;
      if (fsel_we)  fsel_q   <= fsel_d;
    end
  end

  assign raw      = hw_lines | soft_q;
  assign irq_stat = raw & enable_q & ~fsel_q;
  assign fiq_stat = raw & fsel_q;

  // R2: a set write only adds bits, and adds every requested one
  a_r2_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> (((enable_q & $past(enable_q)) == $past(enable_q)) &&
                   ((enable_q & $past(wdata)) == $past(wdata))));
  // R2: a clear write removes the requested bits and keeps the others
  a_r2_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> (((enable_q & $past(wdata)) == '0) &&
                   ((enable_q | $past(wdata)) == ($past(enable_q) | $past(wdata)))));
  // R3: a software clear removes the requested bits
  a_r3_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_we |=> ((soft_q & $past(wdata)) == '0));
endmodule

// File: rtl/vic_slot_table.sv
module vic_slot_table #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  localparam int SRCW = $clog2(NSRC),
  localparam int CTLW = SRCW + 1,
  localparam int SW   = $clog2(NSLOT),
  localparam int LW   = $clog2(NSLOT + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vaddr_we,
  input  logic            vctl_we,
  input  logic            def_we,
  input  logic [SW-1:0]   slot_idx,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] irq_stat,
  input  logic [LW-1:0]   cur_lvl,
  input  logic [LW-1:0]   sel_lvl,
  output logic [DW-1:0]   slot_addr_rd,
  output logic [CTLW-1:0] slot_ctl_rd,
  output logic [DW-1:0]   def_addr,
  output logic [NSRC-1:0] cur_mask,
  output logic [LW-1:0]   pend_lvl,
  output logic [DW-1:0]   sel_addr
);
  logic [DW-1:0]   vaddr_q [NSLOT];
  logic [CTLW-1:0] vctl_q  [NSLOT];
  logic [NSRC-1:0] cum     [NSLOT+1];
  logic [NSLOT-1:0] hit;

  assign cum[0] = '0;

  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    logic            sel;
    logic            slot_on;
    logic [SRCW-1:0] slot_src;
    assign sel      = (slot_idx == SW'(j));
    assign slot_on  = vctl_q[j][SRCW];
    assign slot_src = vctl_q[j][SRCW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vaddr_q[j] <= '0;
        vctl_q[j]  <= '0;
      end else begin
        if (vaddr_we && sel) vaddr_q[j] <= wdata;
        if (vctl_we && sel)  vctl_q[j]  <= wdata[CTLW-1:0];
      end
    end

    assign cum[j+1] = cum[j] | (slot_on ? (NSRC'(1) << slot_src) : '0);
    assign hit[j]   = slot_on & irq_stat[slot_src];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      def_addr <= '0;
    else if (def_we) def_addr <= wdata;
  end

  assign slot_addr_rd = vaddr_q[slot_idx];
  assign slot_ctl_rd  = vctl_q[slot_idx];

  always_comb begin
    cur_mask = '1;
    for (int l = 0; l <= NSLOT; l++)
      if (cur_lvl == LW'(l)) cur_mask = cum[l];
  end

  always_comb begin
    pend_lvl = (|irq_stat) ? LW'(NSLOT) : LW'(NSLOT + 1);
    for (int j = NSLOT - 1; j >= 0; j--)
      if (hit[j]) pend_lvl = LW'(j);
  end

  always_comb begin
    sel_addr = def_addr;
    for (int j = 0; j < NSLOT; j++)
      if (sel_lvl == LW'(j)) sel_addr = vaddr_q[j];
  end

  // R5: no normal-status source means nothing pending (idle code)
  a_r5_idle_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat == '0) |-> (pend_lvl == LW'(NSLOT + 1)));
  // R5: any normal-status source gives a real pending level
  a_r5_some_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat != '0) |-> (pend_lvl <= LW'(NSLOT)));
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
  parameter int NSLOT = 16,
  localparam int LW   = $clog2(NSLOT + 2),
  localparam int NLVL = NSLOT + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          pop,
  input  logic [LW-1:0] pend_lvl,
  output logic [LW-1:0] cur_lvl,
  output logic [LW-1:0] new_lvl
);
  localparam logic [LW-1:0] IDLE = LW'(NSLOT + 1);

  logic [LW-1:0] cur_q, cur_d, prev_lvl;
  logic [LW-1:0] stk_q [NLVL];
  logic [LW-1:0] stk_d [NLVL];
  logic          take, drop;

  assign take = ack && (pend_lvl < cur_q);
  assign drop = pop && (cur_q != IDLE);

  always_comb begin
    prev_lvl = IDLE;
    for (int l = 0; l < NLVL; l++)
      if (cur_q == LW'(l)) prev_lvl = stk_q[l];
  end

  always_comb begin
    cur_d = cur_q;
    for (int l = 0; l < NLVL; l++)
      stk_d[l] = (take && pend_lvl == LW'(l)) ? cur_q : stk_q[l];
    if (take)      cur_d = pend_lvl;
    else if (drop) cur_d = prev_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= IDLE;
      for (int l = 0; l < NLVL; l++) stk_q[l] <= IDLE;
    end else if (take | drop) begin
      cur_q <= cur_d;
      for (int l = 0; l < NLVL; l++) stk_q[l] <= stk_d[l];
    end
  end

  assign cur_lvl = cur_q;
  assign new_lvl = take ? pend_lvl : cur_q;

  // R6: an acknowledge with a higher pending level raises to it
  a_r6_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (pend_lvl < cur_q)) |=> (cur_q == $past(pend_lvl)));
  // R6: an acknowledge with nothing higher leaves the level alone
  a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(pend_lvl < cur_q)) |=> $stable(cur_q));
  // R8: a restore moves to a strictly lower priority
  a_r8_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ack && (cur_q != IDLE)) |=> (cur_q > $past(cur_q)));
  // R8: a restore at idle stays idle
  a_r8_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ack && (cur_q == IDLE)) |=> (cur_q == IDLE));
  // R10: the level never leaves its legal range
  a_r10_lvl_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= IDLE);
endmodule

// File: rtl/nest_vic.sv
module nest_vic #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  import vic_pkg::*;

  localparam int SRCW = $clog2(NSRC);
  localparam int CTLW = SRCW + 1;
  localparam int SW   = $clog2(NSLOT);
  localparam int LW   = $clog2(NSLOT + 2);
  localparam logic [AW-1:0] SPAN = AW'(NSLOT * 4);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // address decode
  logic [AW-1:0] wa;
  logic in_vaddr, in_vctl, in_id;
  assign wa       = {bus_addr[AW-1:2], 2'b00};
  assign in_vaddr = (wa >= AW'(OFS_VADDR)) && (wa < AW'(OFS_VADDR) + SPAN);
  assign in_vctl  = (wa >= AW'(OFS_VCTL))  && (wa < AW'(OFS_VCTL) + SPAN);
  assign in_id    = (wa >= AW'(OFS_ID));

  logic en_set_we, en_clr_we, sw_set_we, sw_clr_we, fsel_we;
  logic prot_we, def_we, vaddr_we, vctl_we, ack, pop;
  assign en_set_we = bus_wr && (wa == AW'(OFS_EN_SET));
  assign en_clr_we = bus_wr && (wa == AW'(OFS_EN_CLR));
  assign sw_set_we = bus_wr && (wa == AW'(OFS_SW_SET));
  assign sw_clr_we = bus_wr && (wa == AW'(OFS_SW_CLR));
  assign fsel_we   = bus_wr && (wa == AW'(OFS_FSEL));
  assign prot_we   = bus_wr && (wa == AW'(OFS_PROT));
  assign def_we    = bus_wr && (wa == AW'(OFS_DEF));
  assign vaddr_we  = bus_wr && in_vaddr;
  assign vctl_we   = bus_wr && in_vctl;
  assign pop       = bus_wr && (wa == AW'(OFS_VEC));
  assign ack       = bus_rd && (wa == AW'(OFS_VEC));

  logic [NSRC-1:0] enable_q, fsel_q, soft_q, raw, irq_stat, fiq_stat;

  vic_src_regs #(.NSRC(NSRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_ni),
    .hw_lines (irq_lines),
    .wdata    (bus_wdata[NSRC-1:0]),
    .en_set_we(en_set_we),
    .en_clr_we(en_clr_we),
    .sw_set_we(sw_set_we),
    .sw_clr_we(sw_clr_we),
    .fsel_we  (fsel_we),
    .enable_q (enable_q),
    .fsel_q   (fsel_q),
    .soft_q   (soft_q),
    .raw      (raw),
    .irq_stat (irq_stat),
    .fiq_stat (fiq_stat)
  );

  logic [LW-1:0]   cur_lvl, new_lvl, pend_lvl;
  logic [DW-1:0]   slot_addr_rd, def_addr, sel_addr;
  logic [CTLW-1:0] slot_ctl_rd;
  logic [NSRC-1:0] cur_mask;

  vic_slot_table #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_slots (
    .clk         (clk),
    .rst_n       (rst_ni),
    .vaddr_we    (vaddr_we),
    .vctl_we     (vctl_we),
    .def_we      (def_we),
    .slot_idx    (bus_addr[SW+1:2]),
    .wdata       (bus_wdata),
    .irq_stat    (irq_stat),
    .cur_lvl     (cur_lvl),
    .sel_lvl     (new_lvl),
    .slot_addr_rd(slot_addr_rd),
    .slot_ctl_rd (slot_ctl_rd),
    .def_addr    (def_addr),
    .cur_mask    (cur_mask),
    .pend_lvl    (pend_lvl),
    .sel_addr    (sel_addr)
  );

  vic_prio_stack #(.NSLOT(NSLOT)) u_stack (
    .clk     (clk),
    .rst_n   (rst_ni),
    .ack     (ack),
    .pop     (pop),
    .pend_lvl(pend_lvl),
    .cur_lvl (cur_lvl),
    .new_lvl (new_lvl)
  );

  // protection bit (stored only)
  logic prot_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      prot_q <= 1'b0;
    else if (prot_we) prot_q <= bus_wdata[0];
  end

  // read path
  logic [DW-1:0] rdata_d, rdata_q;
  always_comb begin
    rdata_d = '0;
    if (in_id)          rdata_d = DW'(id_byte(bus_addr[4:2]));
    else if (in_vaddr)  rdata_d = slot_addr_rd;
    else if (in_vctl)   rdata_d = DW'(slot_ctl_rd);
    else begin
      case (wa)
        AW'(OFS_NSTAT): rdata_d = DW'(irq_stat);
        AW'(OFS_FSTAT): rdata_d = DW'(fiq_stat);
        AW'(OFS_RAW):   rdata_d = DW'(raw);
        AW'(OFS_FSEL):  rdata_d = DW'(fsel_q);
        AW'(OFS_EN_SET): rdata_d = DW'(enable_q);
        AW'(OFS_SW_SET): rdata_d = DW'(soft_q);
        AW'(OFS_PROT):  rdata_d = DW'(prot_q);
        AW'(OFS_VEC):   rdata_d = sel_addr;
        AW'(OFS_DEF):   rdata_d = def_addr;
        default:        rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = |(irq_stat & cur_mask);
  assign fiq_o     = |fiq_stat;

  // R9: the normal request implies a pending level above the current one
  a_r9_irq_has_pend: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (pend_lvl < cur_lvl));
  // R4: a write to the status offset leaves all source state alone
  a_r4_stat_wr_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && wa == AW'(OFS_NSTAT)) |=>
      ($stable(enable_q) && $stable(fsel_q) && $stable(soft_q)));
  // R12: read data is stable while no read is issued
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/nest_vic_bench.sv
`timescale 1ns/1ps
module nest_vic_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o;

  always #2.5 clk = ~clk;

  nest_vic u_nest_vic (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic [31:0] m_en, m_fsel, m_soft, m_def;
  logic        m_prot;
  logic [31:0] m_va [16];
  logic [5:0]  m_vc [16];
  int          m_cur;
  int          m_stk [18];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_raw();
    return irq_lines | m_soft;
  endfunction
  function automatic logic [31:0] f_irqs();
    return f_raw() & m_en & ~m_fsel;
  endfunction
  function automatic logic [31:0] f_mask(input int l);
    logic [31:0] m = '0;
    if (l >= 17) return '1;
    for (int j = 0; j < l; j++)
      if (m_vc[j][5]) m |= 32'd1 << m_vc[j][4:0];
    return m;
  endfunction
  function automatic int f_pend();
    logic [31:0] s = f_irqs();
    for (int j = 0; j < 16; j++)
      if (m_vc[j][5] && s[m_vc[j][4:0]]) return j;
    return (s != 0) ? 16 : 17;
  endfunction
  function automatic logic [7:0] f_id(input int i);
    case (i)
      0: return 8'h90; 1: return 8'h11; 2: return 8'h04; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int p;
    if (a >= 12'hFE0) return {24'd0, f_id(int'((a - 12'hFE0) >> 2))};
    if (a >= 12'h100 && a < 12'h140) return m_va[(a - 12'h100) >> 2];
    if (a >= 12'h200 && a < 12'h240) return {26'd0, m_vc[(a - 12'h200) >> 2]};
    case (a)
      12'h000: return f_irqs();
      12'h004: return f_raw() & m_fsel;
      12'h008: return f_raw();
      12'h00C: return m_fsel;
      12'h010: return m_en;
      12'h018: return m_soft;
      12'h020: return {31'd0, m_prot};
      12'h030: begin
        p = f_pend();
        if (p < m_cur) begin
          m_stk[p] = m_cur;
          m_cur = p;
        end
        return (m_cur < 16) ? m_va[m_cur] : m_def;
      end
      12'h034: return m_def;
      default: return '0;
    endcase
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    if (a >= 12'h100 && a < 12'h140) begin m_va[(a - 12'h100) >> 2] = d; return; end
    if (a >= 12'h200 && a < 12'h240) begin m_vc[(a - 12'h200) >> 2] = d[5:0]; return; end
    case (a)
      12'h00C: m_fsel = d;
      12'h010: m_en   = m_en | d;
      12'h014: m_en   = m_en & ~d;
      12'h018: m_soft = m_soft | d;
      12'h01C: m_soft = m_soft & ~d;
      12'h020: m_prot = d[0];
      12'h030: if (m_cur != 17) m_cur = m_stk[m_cur];
      12'h034: m_def  = d;
      default: ;
    endcase
  endfunction

  task automatic chk_pins(input string req);
    logic ei, ef;
    ei = |(f_irqs() & f_mask(m_cur));
    ef = |(f_raw() & m_fsel);
    chk(irq_o === ei, {req, " irq_o"}, {31'd0, irq_o}, {31'd0, ei});
    chk(fiq_o === ef, {req, " fiq_o"}, {31'd0, fiq_o}, {31'd0, ef});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    model_write(a, d);
    chk_pins(req);
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp = model_read(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    chk(bus_rdata === exp, req, bus_rdata, exp);
    chk_pins(req);
  endtask

  task automatic hw(input logic [31:0] v, input string req);
    @(negedge clk);
    irq_lines = v;
    @(posedge clk); #1;
    chk_pins(req);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_lines = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    m_en = '0; m_fsel = '0; m_soft = '0; m_def = '0; m_prot = 1'b0; m_cur = 17;
    for (int i = 0; i < 16; i++) begin m_va[i] = '0; m_vc[i] = '0; end
    for (int i = 0; i < 18; i++) m_stk[i] = 17;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R10: reset state
    chk_pins("R10");
    rd(12'h030, "R10 vector at idle");
    rd(12'h034, "R10 default addr");
    rd(12'h104, "R10 slot addr");
    rd(12'h208, "R10 slot ctl");
    rd(12'h010, "R10 enable");

    // R11: identification words
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(i * 4), "R11 id");

    // R12: unmapped offset reads zero
    rd(12'h044, "R12 unmapped");

    // R2/R3/R4 basics
    wr(12'h010, 32'h0000_00F0, "R2 set");
    wr(12'h010, 32'h0000_0000, "R2 zero set");
    wr(12'h014, 32'h0000_0030, "R2 clear");
    rd(12'h010, "R2 readback");
    wr(12'h018, 32'h0000_0041, "R3 soft set");
    wr(12'h01C, 32'h0000_0001, "R3 soft clear");
    rd(12'h018, "R3 readback");
    wr(12'h000, 32'hFFFF_FFFF, "R4 status write ignored");
    rd(12'h000, "R4 status after write");
    rd(12'h010, "R4 enable after write");
    wr(12'h020, 32'h0000_0003, "R4 prot");
    rd(12'h020, "R4 prot readback");
    wr(12'h01C, 32'hFFFF_FFFF, "R3 clear all");
    wr(12'h014, 32'hFFFF_FFFF, "R2 clear all");

    // R1: fast routing
    wr(12'h00C, 32'h0000_0100, "R1 fsel");
    wr(12'h010, 32'h0000_0100, "R1 enable fast src");
    hw(32'h0000_0100, "R1 fast line");
    rd(12'h004, "R1 fast status");
    rd(12'h000, "R1 normal status excludes fast");
    rd(12'h008, "R1 raw");
    hw(32'h0, "R1 fast line low");
    wr(12'h00C, 32'h0, "R1 fsel off");

    // R5..R8 nesting
    wr(12'h100, 32'h0000_A000, "R5 slot0 addr");
    wr(12'h104, 32'h0000_B000, "R5 slot1 addr");
    wr(12'h034, 32'h0000_D000, "R6 default addr");
    wr(12'h200, 32'h0000_0023, "R5 slot0 src3");
    wr(12'h204, 32'hFFFF_FF27, "R5 slot1 src7 upper bits dropped");
    rd(12'h204, "R5 ctl readback");
    wr(12'h010, 32'h0010_0088, "R2 enable 3 7 20");
    hw(32'h0000_0080, "R9 src7 at idle");
    rd(12'h030, "R6 ack slot1");
    hw(32'h0010_0080, "R7 lower default blocked");
    hw(32'h0010_0088, "R7 higher pre-empts");
    rd(12'h030, "R6 ack slot0");
    rd(12'h030, "R6 re-read same level");
    wr(12'h030, 32'h1234_5678, "R8 pop to slot1");
    hw(32'h0010_0080, "R9 src3 dropped");
    wr(12'h030, 32'h0, "R8 pop to idle");
    wr(12'h030, 32'h0, "R8 pop at idle");
    wr(12'h204, 32'h0, "R5 slot1 off");
    rd(12'h030, "R6 ack default");
    hw(32'h0000_0088, "R7 slot source above default");
    rd(12'h030, "R6 ack slot0 over default");
    wr(12'h030, 32'h0, "R8 pop to default");
    wr(12'h030, 32'h0, "R8 pop to idle");
    hw(32'h0, "R9 lines low");

    // random phase
    for (int it = 0; it < 600; it++) begin
      case ($urandom_range(0, 11))
        0: hw($urandom & $urandom & $urandom, "R9 rand lines");
        1: wr(12'h010, $urandom & $urandom, "R2 rand set");
        2: wr(12'h014, $urandom & $urandom, "R2 rand clear");
        3: wr(12'h018, $urandom & $urandom & $urandom, "R3 rand soft set");
        4: wr(12'h01C, $urandom, "R3 rand soft clear");
        5: wr(12'h00C, $urandom & $urandom & $urandom, "R1 rand fsel");
        6: wr(12'h200 + 12'($urandom_range(0, 15) * 4), $urandom, "R5 rand ctl");
        7: wr(12'h100 + 12'($urandom_range(0, 15) * 4), $urandom, "R5 rand addr");
        8, 9: rd(12'h030, "R6 rand ack");
        10: wr(12'h030, $urandom, "R8 rand pop");
        default: begin
          v = 32'($urandom_range(0, 6) * 4);
          rd(v[11:0], "R1 rand status read");
        end
      endcase
    end
    for (int i = 0; i < 18; i++) wr(12'h030, 32'h0, "R8 drain");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule